// File: doc/BRIEF.md
# Multi-Cycle Execute Stall Interlock

This block is the flow control for a four-stage in-order pipeline: fetch, decode, execute, write. Two buffers carry instructions forward, one from fetch into decode and one from decode into execute. Most operations spend a single cycle in execute. Long operations, such as a divide, stay in execute for two or three consecutive cycles, and the execute unit is not pipelined.

While a long operation is still running, the block raises hold enables for the program counter and for both inter-stage buffers. This freezes fetch and decode, so their next steps slip by exactly the number of extra execute cycles. In each of those cycles the write stage receives a bubble. When the last execute cycle ends, the result reaches write and the waiting instruction moves into execute on the same edge. No instruction is lost and none is repeated.

The operands are copied into a private register at the edge where an instruction enters execute. Because of that copy, the execute unit does not rely on the upstream buffer staying constant. Decode supplies a 2-bit latency code with each instruction it hands on. The block tracks a valid bit for every stage and keeps a down-counter of the execute cycles that remain.

Top module: `exec_stall_ctrl`

## Requirements
- R1: After reset, the fetch/decode, decode/execute and execute valid bits are 0. The write valid is 0 and all three hold enables are 0.
- R2: Latency code 0 gives one execute cycle, code 1 gives two, and code 2 gives three. Code 3 is reserved and gives one cycle. An isolated instruction therefore keeps the holds high for exactly (cycles - 1) clock cycles.
- R3: During every extra execute cycle, the PC, fetch/decode and decode/execute hold enables are all high, and the fetch/decode and decode/execute valid bits keep their values at the next edge.
- R4: The write valid goes high for exactly one cycle per executed instruction. That cycle is the one right after the instruction's last execute cycle. The write valid is low after every cycle in which the holds are high.
- R5: Once fetch input stops and the pipeline drains, the number of write-valid pulses equals the number of instructions accepted from fetch, and the pulses come in fetch order.
- R6: The execute operand output takes the decode/execute buffer contents at the edge where an instruction enters execute, and it stays unchanged for every execute cycle of that instruction.
- R7: At most one instruction occupies execute at a time. A new instruction enters execute only on an edge after a cycle in which the holds are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_vld_i | input | 1 | Fetch produced an instruction this cycle |
| dec_lat_i | input | LAT_W | Latency code of the instruction now in decode |
| de_opnd_i | input | DATA_W | Contents of the decode/execute buffer |
| pc_hold_o | output | 1 | Keep the program counter |
| fd_hold_o | output | 1 | Keep the fetch/decode buffer |
| de_hold_o | output | 1 | Keep the decode/execute buffer |
| fd_vld_o | output | 1 | Fetch/decode buffer holds an instruction |
| de_vld_o | output | 1 | Decode/execute buffer holds an instruction |
| ex_vld_o | output | 1 | Execute holds an instruction |
| ex_opnd_o | output | DATA_W | Operands captured on entry to execute |
| wr_vld_o | output | 1 | Write stage receives a result this cycle |

## Verification
The bench aims at back-to-back long operations, a long operation followed at once by a one-cycle one, and the reserved code. A design that loads the counter with the full latency would stretch every stall by one cycle. A design that treats code 3 as four cycles would stall where none is due. Bench buffers follow the hold enables and carry instruction numbers, so a design that lets decode advance during a stall would skip or repeat numbers on the execute operand output and in the write order. A design that writes during a bubble would produce extra write pulses, and these show up in the drain count.

// File: rtl/stall_pkg.sv
package stall_pkg;

   // Number of execute cycles for a latency code; the all-ones code is reserved.
   function automatic int unsigned code_cycles(int unsigned code, int unsigned lat_w);
      int unsigned reserved;
      reserved = (1 << lat_w) - 1;
      if (code >= reserved) return 1;
      return code + 1;
   endfunction

   // Largest cycle count any non-reserved code can ask for.
   function automatic int unsigned max_cycles(int unsigned lat_w);
      return (1 << lat_w) - 1;
   endfunction

endpackage

// File: rtl/exec_busy_counter.sv
module exec_busy_counter
   import stall_pkg::*;
#(
   parameter int unsigned LAT_W = 2,
   localparam int unsigned MAX_CYC = (1 << LAT_W) - 1,
   localparam int unsigned CNT_W = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [LAT_W-1:0] code_i,
   output logic             busy_o
);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] load_val;

   always_comb begin
      load_val = CNT_W'(code_cycles(int'(code_i), LAT_W) - 1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end else if (load_i) begin
         cnt_q <= load_val;
      end
   end

   assign busy_o = (cnt_q != '0);

   a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
      int'(cnt_q) <= int'(MAX_CYC) - 1);

   a_r3_count_down: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/stage_valid_track.sv
module stage_valid_track #(
   parameter int unsigned NBUF = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            hold_i,
   input  logic            in_vld_i,
   output logic [NBUF-1:0] buf_vld_o,
   output logic            ex_vld_o
);

   logic [NBUF:0] chain;
   assign chain[0] = in_vld_i;

   for (genvar g = 0; g < NBUF; g++) begin : g_buf
      logic vld_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       vld_q <= 1'b0;
         else if (!hold_i) vld_q <= chain[g];
      end
      assign chain[g+1]   = vld_q;
      assign buf_vld_o[g] = vld_q;
   end

   logic ex_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ex_q <= 1'b0;
      else if (!hold_i) ex_q <= chain[NBUF];
   end
   assign ex_vld_o = ex_q;

   a_r3_buffers_kept: assert property (@(posedge clk) disable iff (!rst_n)
      hold_i |=> $stable(buf_vld_o));

   a_r7_single_occupant: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_i && ex_q) |=> ex_q);

endmodule

// File: rtl/operand_snap.sv
module operand_snap #(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              take_i,
   input  logic              hold_i,
   input  logic [DATA_W-1:0] opnd_i,
   output logic [DATA_W-1:0] opnd_o
);

   logic [DATA_W-1:0] opnd_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      opnd_q <= '0;
      else if (take_i) opnd_q <= opnd_i;
   end
   assign opnd_o = opnd_q;

   a_r6_operand_stable: assert property (@(posedge clk) disable iff (!rst_n)
      hold_i |=> $stable(opnd_q));

endmodule

// File: rtl/exec_stall_ctrl.sv
module exec_stall_ctrl
   import stall_pkg::*;
#(
   parameter int unsigned LAT_W  = 2,
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fetch_vld_i,
   input  logic [LAT_W-1:0]  dec_lat_i,
   input  logic [DATA_W-1:0] de_opnd_i,
   output logic              pc_hold_o,
   output logic              fd_hold_o,
   output logic              de_hold_o,
   output logic              fd_vld_o,
   output logic              de_vld_o,
   output logic              ex_vld_o,
   output logic [DATA_W-1:0] ex_opnd_o,
   output logic              wr_vld_o
);

   localparam int unsigned NBUF = 2;

   if (LAT_W < 2) begin : g_bad_lat
      $error("LAT_W must be at least 2");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("DATA_W must be at least 1");
   end

   logic            busy;
   logic [NBUF-1:0] buf_vld;
   logic            ex_vld;
   logic            enter_ex;
   logic [LAT_W-1:0] de_lat_q;
   logic            wr_q;

   stage_valid_track #(.NBUF(NBUF)) u_track (
      .clk      (clk),
      .rst_n    (rst_n),
      .hold_i   (busy),
      .in_vld_i (fetch_vld_i),
      .buf_vld_o(buf_vld),
      .ex_vld_o (ex_vld)
   );

   // Latency code travels with the instruction in the decode/execute buffer.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     de_lat_q <= '0;
      else if (!busy) de_lat_q <= dec_lat_i;
   end

   assign enter_ex = !busy && buf_vld[NBUF-1];

   exec_busy_counter #(.LAT_W(LAT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .load_i(enter_ex),
      .code_i(de_lat_q),
      .busy_o(busy)
   );

   operand_snap #(.DATA_W(DATA_W)) u_snap (
      .clk   (clk),
      .rst_n (rst_n),
      .take_i(enter_ex),
      .hold_i(busy),
      .opnd_i(de_opnd_i),
      .opnd_o(ex_opnd_o)
   );

   // Result reaches write after the final execute cycle; bubbles otherwise.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) wr_q <= 1'b0;
      else        wr_q <= ex_vld && !busy;
   end

   assign pc_hold_o = busy;
   assign fd_hold_o = busy;
   assign de_hold_o = busy;
   assign fd_vld_o  = buf_vld[0];
   assign de_vld_o  = buf_vld[NBUF-1];
   assign ex_vld_o  = ex_vld;
   assign wr_vld_o  = wr_q;

   a_r4_bubble_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> !wr_vld_o);

   a_r4_write_needs_exec: assert property (@(posedge clk) disable iff (!rst_n)
      !ex_vld |=> !wr_vld_o);

   a_r3_holds_agree: assert property (@(posedge clk) disable iff (!rst_n)
      (pc_hold_o == fd_hold_o) && (fd_hold_o == de_hold_o));

endmodule

// File: tb/exec_stall_ctrl_tb_top.sv
module exec_stall_ctrl_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       fetch_vld_i = 1'b0;
   logic [1:0] dec_lat_i = '0;
   logic [7:0] de_opnd_i = '0;
   logic       pc_hold_o, fd_hold_o, de_hold_o;
   logic       fd_vld_o, de_vld_o, ex_vld_o, wr_vld_o;
   logic [7:0] ex_opnd_o;

   always #5 clk = ~clk;

   exec_stall_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .fetch_vld_i(fetch_vld_i), .dec_lat_i(dec_lat_i),
      .de_opnd_i(de_opnd_i), .pc_hold_o(pc_hold_o), .fd_hold_o(fd_hold_o),
      .de_hold_o(de_hold_o), .fd_vld_o(fd_vld_o), .de_vld_o(de_vld_o),
      .ex_vld_o(ex_vld_o), .ex_opnd_o(ex_opnd_o), .wr_vld_o(wr_vld_o)
   );

   int unsigned errors = 0;
   int unsigned checks = 0;

   // Reference model state
   bit       m_fd, m_de, m_ex, m_wr;
   int       m_rem;
   int       m_fdid, m_deid, m_exid, m_wrid;
   int       next_id = 1;
   int       next_wr = 1;
   int       wr_count = 0;
   int       hold_cycles = 0;
   bit [1:0] lat_of [0:4095];

   function automatic int cyc(bit [1:0] c);
      return (c == 2'd3) ? 1 : int'(c) + 1;
   endfunction

   task automatic chk(bit ok, string req, string what, int act, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic compare();
      bit busy;
      busy = (m_rem != 0);
      chk(pc_hold_o == busy, "R3", "pc_hold", pc_hold_o, busy);
      chk(fd_hold_o == busy && de_hold_o == busy, "R3", "buf_hold",
          {fd_hold_o, de_hold_o}, {busy, busy});
      chk(fd_vld_o == m_fd && de_vld_o == m_de, "R3", "buffer valid",
          {fd_vld_o, de_vld_o}, {m_fd, m_de});
      chk(ex_vld_o == m_ex, "R7", "ex valid", ex_vld_o, m_ex);
      chk(wr_vld_o == m_wr, "R4", "write valid", wr_vld_o, m_wr);
      if (m_ex)
         chk(ex_opnd_o == 8'(m_exid), "R6", "ex operand", ex_opnd_o, m_exid & 255);
      if (m_wr) begin
         chk(m_wrid == next_wr, "R5", "write order", m_wrid, next_wr);
         next_wr++;
         wr_count++;
      end
      if (busy) hold_cycles++;
   endtask

   // One cycle: compare at negedge, drive inputs, advance model after edge.
   task automatic step(bit fv, bit [1:0] lat);
      bit busy;
      @(negedge clk);
      compare();
      fetch_vld_i = fv;
      if (fv && !(m_rem != 0)) lat_of[next_id % 4096] = lat;
      dec_lat_i = lat_of[m_fdid % 4096];
      de_opnd_i = 8'(m_deid);
      @(posedge clk);
      #1;
      busy = (m_rem != 0);
      m_wr = m_ex && !busy;
      m_wrid = m_exid;
      if (busy) m_rem--;
      else begin
         m_ex = m_de; m_exid = m_deid;
         m_rem = m_de ? cyc(lat_of[m_deid % 4096]) - 1 : 0;
         m_de = m_fd; m_deid = m_fdid;
         m_fd = fv;
         if (fv) begin m_fdid = next_id; next_id++; end
      end
   endtask

   initial begin
      #200000000;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      // R1 reset state
      chk({fd_vld_o, de_vld_o, ex_vld_o, wr_vld_o} == 4'b0, "R1", "valids", 
          {fd_vld_o, de_vld_o, ex_vld_o, wr_vld_o}, 0);
      chk({pc_hold_o, fd_hold_o, de_hold_o} == 3'b0, "R1", "holds",
          {pc_hold_o, fd_hold_o, de_hold_o}, 0);
      rst_n = 1'b1;

      // R2 isolated instructions per code
      for (int c = 0; c < 4; c++) begin
         hold_cycles = 0;
         step(1'b1, 2'(c));
         repeat (8) step(1'b0, 2'd0);
         chk(hold_cycles == cyc(2'(c)) - 1, "R2", "stall cycles", hold_cycles,
             cyc(2'(c)) - 1);
      end

      // Directed: back-to-back long ops, long then short, reserved code
      step(1'b1, 2'd2); step(1'b1, 2'd2); step(1'b1, 2'd0); step(1'b1, 2'd3);
      step(1'b1, 2'd1); step(1'b1, 2'd2); step(1'b1, 2'd0);
      repeat (12) step(1'b0, 2'd0);

      // Constrained random
      for (int i = 0; i < 3000; i++)
         step(1'(($urandom % 4) != 0), 2'($urandom % 4));

      // Drain, then R5 accounting
      repeat (20) step(1'b0, 2'd0);
      chk(wr_count == next_id - 1, "R5", "write count", wr_count, next_id - 1);

      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule